// File: doc/BRIEF.md
# Digital Potentiometer Wiper Controller

This block is the control section of a tapped resistive divider with a parameterized number of taps (100 by default). A host moves the wiper over a three-wire pin interface: an active-low select line, a step strobe and a direction line. All three pins are asynchronous to the system clock. They are brought into the clock domain through a chain of synchronizer flops. While the block is selected, each falling edge of the step strobe moves the wiper one tap up or down. The wiper stops at either end tap and never wraps. The block drives a one-hot tap-select vector that closes exactly one wiper switch of the external resistor array.

The wiper position can be kept in a modelled nonvolatile cell, which holds its content across resets. The select line is released either with the strobe high or with it low. With the strobe high, the position is committed to the cell, and the block stays busy for a long write interval. With the strobe low, the access ends without a commit, and a short quiet interval follows before the next access. After reset, which stands for power-up, the block waits through a settle interval and then loads the wiper from the cell. All intervals are counted in clock cycles.

Top module: `dpot_wiper_ctrl`

## Requirements
- R1: After reset, `busy` stays high for exactly SETTLE_CYC clock cycles and `store_done` stays low. When `busy` falls, `wiper_pos` holds the content of the nonvolatile cell, which is NV_INIT on the first power-up.
- R2: While `sel_n` is high, activity on `inc` and `up_dn` leaves `wiper_pos` unchanged.
- R3: While selected and not busy, a falling edge of `inc` moves `wiper_pos` by one. The move is up when `up_dn` is 1 and down when it is 0. The new value appears on the third rising clock edge after the edge and not earlier.
- R4: A step up at tap TAPS-1 leaves the position at TAPS-1.
- R5: A step down at tap 0 leaves the position at 0.
- R6: `tap_sel` always has exactly one bit set, and that bit's index equals `wiper_pos`.
- R7: A rising edge of `sel_n` while `inc` is high starts a commit. `busy` stays high for exactly STORE_CYC cycles. At the end, `store_done` pulses high for one cycle and the cell takes the current position.
- R8: A rising edge of `sel_n` while `inc` is low ends the access without a commit. `busy` and `store_done` stay low. Interface activity during the next GAP_CYC cycles is ignored.
- R9: While `busy` is high, all interface activity is ignored and `wiper_pos` does not change.
- R10: After a reset, the position recalled is the last committed one, not a later uncommitted position.
- R11: A rising edge of `inc` never moves the wiper.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| sel_n | input | 1 | Active-low select, asynchronous |
| inc | input | 1 | Step strobe, wiper moves on its falling edge, asynchronous |
| up_dn | input | 1 | Direction: 1 steps up, 0 steps down, asynchronous |
| tap_sel | output | TAPS | One-hot wiper switch select |
| wiper_pos | output | $clog2(TAPS) | Current wiper position |
| busy | output | 1 | Settle/recall or commit in progress |
| store_done | output | 1 | One-cycle pulse when a commit completes |

## Verification
The bench builds the block with the full 100-tap range and a two-stage synchronizer. It selects the registered tap-decode variant. The settle interval is 40 cycles, the commit interval 50 and the quiet interval 10. The short intervals let a run include two power-ups, a commit measured cycle by cycle and a strobe burst during a commit. The full tap range lets both end stops be driven past their limits. NV_INIT is 37, so the first recall is told apart from the reset value of the counter.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

   // Control sequencer states
   typedef enum logic [1:0] {
      CS_SETTLE,   // power-up settle, followed by recall
      CS_READY,    // accepting interface activity
      CS_STORE,    // nonvolatile commit in progress
      CS_GAP       // quiet interval after deselect without commit
   } ctl_state_e;

   // Bit order of the synchronized pin vector
   localparam int PIN_SEL = 2;
   localparam int PIN_INC = 1;
   localparam int PIN_UP  = 0;
   localparam int PIN_W   = 3;

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
   parameter int               STAGES  = 2,
   parameter int               W       = 1,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dpot_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d};
   end

   assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
   import dpot_pkg::*;
#(
   parameter int POS_W      = 7,
   parameter int SETTLE_CYC = 100000,
   parameter int STORE_CYC  = 2000000,
   parameter int GAP_CYC    = 100,
   parameter int NV_INIT    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n_s,
   input  logic             inc_s,
   input  logic [POS_W-1:0] pos,
   output logic             step,
   output logic             load,
   output logic [POS_W-1:0] nv_val,
   output logic             busy,
   output logic             store_done
);

   localparam int MAX_AB = (SETTLE_CYC > STORE_CYC) ? SETTLE_CYC : STORE_CYC;
   localparam int MAX_C  = (MAX_AB > GAP_CYC) ? MAX_AB : GAP_CYC;
   localparam int TMR_W  = $clog2(MAX_C + 1);

   ctl_state_e       state_q;
   logic [TMR_W-1:0] tmr_q;
   logic             sel_prev_q, inc_prev_q;
   logic             done_q;
   logic [POS_W-1:0] nv_cell = POS_W'(NV_INIT);   // survives reset

   logic sel_rise, inc_fall, tmr_zero, ready;

   assign sel_rise = ~sel_prev_q & sel_n_s;
   assign inc_fall = inc_prev_q & ~inc_s;
   assign tmr_zero = (tmr_q == '0);
   assign ready    = (state_q == CS_READY);

   assign step       = ready & ~sel_n_s & inc_fall;
   assign load       = (state_q == CS_SETTLE) & tmr_zero;
   assign busy       = (state_q == CS_SETTLE) | (state_q == CS_STORE);
   assign nv_val     = nv_cell;
   assign store_done = done_q;

   // Edge history tracks the pins in every state, so activity while
   // busy leaves no stale edge behind.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_prev_q <= 1'b1;
         inc_prev_q <= 1'b1;
      end else begin
         sel_prev_q <= sel_n_s;
         inc_prev_q <= inc_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CS_SETTLE;
         tmr_q   <= TMR_W'(SETTLE_CYC - 1);
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            CS_SETTLE: begin
               if (tmr_zero) state_q <= CS_READY;
               else          tmr_q   <= tmr_q - TMR_W'(1);
            end
            CS_READY: begin
               if (sel_rise) begin
                  if (inc_s) begin
                     state_q <= CS_STORE;
                     tmr_q   <= TMR_W'(STORE_CYC - 1);
                  end else begin
                     state_q <= CS_GAP;
                     tmr_q   <= TMR_W'(GAP_CYC - 1);
                  end
               end
            end
            CS_STORE: begin
               if (tmr_zero) begin
                  state_q <= CS_READY;
                  done_q  <= 1'b1;
               end else begin
                  tmr_q <= tmr_q - TMR_W'(1);
               end
            end
            default: begin
               if (tmr_zero) state_q <= CS_READY;
               else          tmr_q   <= tmr_q - TMR_W'(1);
            end
         endcase
      end
   end

   // Nonvolatile cell: written only when a commit interval expires.
   always_ff @(posedge clk) begin
      if ((state_q == CS_STORE) && tmr_zero) nv_cell <= pos;
   end

endmodule

// File: rtl/dpot_wiper.sv
module dpot_wiper #(
   parameter int TAPS       = 100,
   parameter int POS_W      = 7,
   parameter bit REG_DECODE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             up,
   input  logic             load,
   input  logic [POS_W-1:0] load_val,
   output logic [POS_W-1:0] pos,
   output logic [TAPS-1:0]  tap_sel
);

   localparam logic [POS_W-1:0] LAST = POS_W'(TAPS - 1);

   logic [POS_W-1:0] pos_q, pos_nxt;

   function automatic logic [TAPS-1:0] one_hot(input logic [POS_W-1:0] p);
      logic [TAPS-1:0] v;
      v = '0;
      for (int i = 0; i < TAPS; i++) v[i] = (p == POS_W'(i));
      return v;
   endfunction

   always_comb begin
      pos_nxt = pos_q;
      if (load) begin
         pos_nxt = load_val;
      end else if (step) begin
         if (up && (pos_q != LAST))       pos_nxt = pos_q + POS_W'(1);
         else if (!up && (pos_q != '0))   pos_nxt = pos_q - POS_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= '0;
      else        pos_q <= pos_nxt;
   end

   assign pos = pos_q;

   if (REG_DECODE) begin : g_dec_reg
      // Decode ahead of the counter so the switch select leaves a flop.
      logic [TAPS-1:0] tap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tap_q <= one_hot('0);
         else        tap_q <= one_hot(pos_nxt);
      end
      assign tap_sel = tap_q;
   end else begin : g_dec_comb
      for (genvar t = 0; t < TAPS; t++) begin : g_tap
         assign tap_sel[t] = (pos_q == POS_W'(t));
      end
   end

endmodule

// File: rtl/dpot_wiper_ctrl.sv
module dpot_wiper_ctrl
   import dpot_pkg::*;
#(
   parameter int  TAPS        = 100,
   parameter int  SYNC_STAGES = 2,
   parameter int  SETTLE_CYC  = 100000,
   parameter int  STORE_CYC   = 2000000,
   parameter int  GAP_CYC     = 100,
   parameter int  NV_INIT     = 0,
   parameter bit  REG_DECODE  = 1'b0,
   localparam int POS_W       = $clog2(TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n,
   input  logic             inc,
   input  logic             up_dn,
   output logic [TAPS-1:0]  tap_sel,
   output logic [POS_W-1:0] wiper_pos,
   output logic             busy,
   output logic             store_done
);

   if (TAPS < 2) begin : g_bad_taps
      $error("dpot_wiper_ctrl: TAPS must be at least 2");
   end
   if ((NV_INIT < 0) || (NV_INIT >= TAPS)) begin : g_bad_init
      $error("dpot_wiper_ctrl: NV_INIT outside tap range");
   end
   if ((SETTLE_CYC < 1) || (STORE_CYC < 1) || (GAP_CYC < 1)) begin : g_bad_cyc
      $error("dpot_wiper_ctrl: interval counts must be at least 1");
   end

   logic [PIN_W-1:0] pins_s;
   logic             step, load;
   logic [POS_W-1:0] nv_val;

   dpot_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (PIN_W),
      .RST_VAL (3'b110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sel_n, inc, up_dn}),
      .q     (pins_s)
   );

   dpot_ctrl #(
      .POS_W      (POS_W),
      .SETTLE_CYC (SETTLE_CYC),
      .STORE_CYC  (STORE_CYC),
      .GAP_CYC    (GAP_CYC),
      .NV_INIT    (NV_INIT)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_n_s    (pins_s[PIN_SEL]),
      .inc_s      (pins_s[PIN_INC]),
      .pos        (wiper_pos),
      .step       (step),
      .load       (load),
      .nv_val     (nv_val),
      .busy       (busy),
      .store_done (store_done)
   );

   dpot_wiper #(
      .TAPS       (TAPS),
      .POS_W      (POS_W),
      .REG_DECODE (REG_DECODE)
   ) u_wiper (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .up       (pins_s[PIN_UP]),
      .load     (load),
      .load_val (nv_val),
      .pos      (wiper_pos),
      .tap_sel  (tap_sel)
   );

endmodule

// File: rtl/dpot_wiper_ctrl_chk.sv
module dpot_wiper_ctrl_chk #(
   parameter int TAPS  = 100,
   parameter int POS_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [TAPS-1:0]  tap_sel,
   input logic [POS_W-1:0] wiper_pos,
   input logic             busy,
   input logic             store_done
);

   // R6
   a_r6_onehot_match: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

   // R4, R5
   a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wiper_pos) < TAPS);

   // R3
   a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> (wiper_pos == $past(wiper_pos)) ||
                       (wiper_pos == $past(wiper_pos) + POS_W'(1)) ||
                       (wiper_pos == $past(wiper_pos) - POS_W'(1)));

   // R9
   a_r9_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(wiper_pos));

   // R7
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      store_done |=> !store_done);

   // R7
   a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      store_done |-> (!busy && $past(busy)));

endmodule

bind dpot_wiper_ctrl dpot_wiper_ctrl_chk #(
   .TAPS  (TAPS),
   .POS_W (POS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tap_sel    (tap_sel),
   .wiper_pos  (wiper_pos),
   .busy       (busy),
   .store_done (store_done)
);

// File: tb/dpot_wiper_ctrl_bench.sv
`timescale 1ns/1ps
module dpot_wiper_ctrl_bench;

   localparam int TAPS   = 100;
   localparam int POS_W  = $clog2(TAPS);
   localparam int SETTLE = 40;
   localparam int STORE  = 50;
   localparam int GAP    = 10;
   localparam int INIT   = 37;

   logic clk = 1'b0;
   logic rst_n, sel_n, inc, up_dn;
   logic [TAPS-1:0]  tap_sel;
   logic [POS_W-1:0] wiper_pos;
   logic busy, store_done;

   int n_chk = 0;
   int n_bad = 0;
   int busy_cnt = 0;
   int done_cnt = 0;

   always #5 clk = ~clk;

   dpot_wiper_ctrl #(
      .TAPS(TAPS), .SYNC_STAGES(2), .SETTLE_CYC(SETTLE), .STORE_CYC(STORE),
      .GAP_CYC(GAP), .NV_INIT(INIT), .REG_DECODE(1'b1)
   ) u_dpot_wiper_ctrl (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .inc(inc), .up_dn(up_dn),
      .tap_sel(tap_sel), .wiper_pos(wiper_pos), .busy(busy),
      .store_done(store_done)
   );

   always @(negedge clk) begin
      if (rst_n && busy)       busy_cnt++;
      if (rst_n && store_done) done_cnt++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int tap_index();
      int idx = -1;
      if ($countones(tap_sel) != 1) return -1;
      for (int i = 0; i < TAPS; i++) if (tap_sel[i]) idx = i;
      return idx;
   endfunction

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_pos(input string req, input int exp);
      chk(int'(wiper_pos) == exp, req, int'(wiper_pos), exp);
      chk(tap_index() == exp, "R6", tap_index(), exp);
   endtask

   task automatic pulse(input bit up);
      up_dn = up;
      wait_n(3);
      inc = 1'b0;
      wait_n(5);
      inc = 1'b1;
      wait_n(5);
   endtask

   task automatic select();
      sel_n = 1'b0;
      wait_n(4);
   endtask

   task automatic power_up(input int exp, input string req);
      rst_n = 1'b0; sel_n = 1'b1; inc = 1'b1; up_dn = 1'b0;
      wait_n(4);
      rst_n = 1'b1;
      wait_n(SETTLE - 2);
      chk(busy == 1'b1, "R1", busy, 1);
      chk(store_done == 1'b0, "R1", store_done, 0);
      wait_n(3);
      chk(busy == 1'b0, "R1", busy, 0);
      check_pos(req, exp);
   endtask

   task automatic t_ignore_deselected();
      int b0 = busy_cnt;
      for (int i = 0; i < 4; i++) begin
         pulse(1'b1);
         pulse(1'b0);
      end
      pulse(1'b1);
      check_pos("R2", INIT);
      chk(busy_cnt == b0, "R2", busy_cnt - b0, 0);
   endtask

   task automatic t_step();
      select();
      up_dn = 1'b1;
      wait_n(3);
      inc = 1'b0;
      wait_n(2);
      chk(int'(wiper_pos) == INIT, "R3", int'(wiper_pos), INIT);
      wait_n(2);
      check_pos("R3", INIT + 1);
      inc = 1'b1;
      wait_n(5);
      check_pos("R11", INIT + 1);
      for (int i = 0; i < 4; i++) pulse(1'b1);
      check_pos("R3", INIT + 5);
      pulse(1'b0);
      pulse(1'b0);
      check_pos("R3", INIT + 3);
   endtask

   task automatic t_saturate();
      for (int i = 0; i < TAPS - 1 - (INIT + 3); i++) pulse(1'b1);
      check_pos("R4", TAPS - 1);
      for (int i = 0; i < 3; i++) pulse(1'b1);
      check_pos("R4", TAPS - 1);
      for (int i = 0; i < TAPS - 1; i++) pulse(1'b0);
      check_pos("R5", 0);
      for (int i = 0; i < 3; i++) pulse(1'b0);
      check_pos("R5", 0);
   endtask

   task automatic t_store();
      int b0, d0;
      for (int i = 0; i < 12; i++) pulse(1'b1);
      check_pos("R3", 12);
      b0 = busy_cnt; d0 = done_cnt;
      sel_n = 1'b1;
      wait_n(STORE + 20);
      chk(busy_cnt - b0 == STORE, "R7", busy_cnt - b0, STORE);
      chk(done_cnt - d0 == 1, "R7", done_cnt - d0, 1);
      check_pos("R7", 12);
   endtask

   task automatic t_busy_ignore();
      int d0;
      select();
      d0 = done_cnt;
      sel_n = 1'b1;
      wait_n(4);
      chk(busy == 1'b1, "R9", busy, 1);
      sel_n = 1'b0;
      for (int i = 0; i < 3; i++) pulse(1'b1);
      sel_n = 1'b1;
      wait_n(STORE);
      chk(busy == 1'b0, "R9", busy, 0);
      check_pos("R9", 12);
      chk(done_cnt - d0 == 1, "R9", done_cnt - d0, 1);
   endtask

   task automatic t_nostore();
      int b0, d0;
      select();
      pulse(1'b1);
      check_pos("R3", 13);
      up_dn = 1'b1;
      inc = 1'b0;
      wait_n(5);
      check_pos("R3", 14);
      b0 = busy_cnt; d0 = done_cnt;
      sel_n = 1'b1; wait_n(1);
      inc = 1'b1;   wait_n(1);
      sel_n = 1'b0; wait_n(1);
      inc = 1'b0;   wait_n(1);
      sel_n = 1'b1; wait_n(1);
      inc = 1'b1;
      wait_n(20);
      check_pos("R8", 14);
      chk(busy_cnt == b0, "R8", busy_cnt - b0, 0);
      chk(done_cnt == d0, "R8", done_cnt - d0, 0);
      select();
      pulse(1'b1);
      check_pos("R8", 15);
   endtask

   initial begin
      #2000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; sel_n = 1'b1; inc = 1'b1; up_dn = 1'b0;
      power_up(INIT, "R1");
      t_ignore_deselected();
      t_step();
      t_saturate();
      t_store();
      t_busy_ignore();
      t_nostore();
      power_up(12, "R10");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule